// File: doc/BRIEF.md
# Bounded Stack Pointer Unit

This block owns the system stack pointer for a stack of 16-bit words held in on-chip RAM. The stack grows toward lower addresses. A push moves the pointer down by two bytes and then writes the word at the new pointer. A pop reads the word at the current pointer and then moves the pointer up by two bytes. Every RAM access goes out through a simple request/grant port. An access completes in the cycle in which the grant is high.

Each completed access is checked against two programmable bounds: a low-water bound for overflow and a high-water bound for underflow. A breach sets a separate sticky flag for each bound. The access that breaches a bound is still carried out. Software can overwrite the pointer and either bound at any time, and it clears each flag with its own strobe.

Top module: `stk_guard`

## Requirements
- R1: After reset, `sp_out` equals SP_INIT (0x600), both flags are 0, and `mem_req` is 0.
- R2: A push drives `mem_req`=1, `mem_we`=1, `mem_addr`=`sp_out`-2 and `mem_wdata`=`push_data`. When the grant arrives, `sp_out` becomes `sp_out`-2 on the next cycle.
- R3: A pop drives `mem_req`=1, `mem_we`=0 and `mem_addr`=`sp_out`. When the grant arrives, `sp_out` becomes `sp_out`+2, and in the next cycle `pop_valid` is 1 and `pop_data` holds the word read.
- R4: A software write to the pointer stores the written value with bit 0 forced to 0. The bounds are stored with bit 0 cleared in the same way.
- R5: `ovf_flag` is set when a granted push leaves the pointer less than or equal to the overflow bound (equality sets the flag).
- R6: `unf_flag` is set when a granted pop leaves the pointer strictly greater than the underflow bound (equality does not set the flag).
- R7: Each flag holds until its clear strobe (`clr_ovf` or `clr_unf`). In a cycle where a new breach and a clear coincide, the flag stays set. The breaching access still updates the pointer.
- R8: When `push_req` and `pop_req` are both high, only the push is performed. While `sp_wr` is high, no access is issued (`mem_req`=0).
- R9: While a request is pending without a grant, `sp_out` and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push a word |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Request to pop a word |
| pop_valid | output | 1 | Popped word valid (one cycle) |
| pop_data | output | 16 | Popped word |
| acc_done | output | 1 | Access granted this cycle |
| sp_wr | input | 1 | Software pointer write strobe |
| sp_wdata | input | AW | Pointer value to write |
| ovl_wr | input | 1 | Overflow bound write strobe |
| ovl_wdata | input | AW | Overflow bound value |
| unl_wr | input | 1 | Underflow bound write strobe |
| unl_wdata | input | AW | Underflow bound value |
| clr_ovf | input | 1 | Clear overflow flag |
| clr_unf | input | 1 | Clear underflow flag |
| sp_out | output | AW | Current stack pointer |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| mem_gnt | input | 1 | RAM grant |
| mem_rdata | input | 16 | RAM read data, valid with the grant |

## Verification
A corrupted pointer shows on `sp_out` and on the next `mem_addr` one cycle after the access that damaged it. It also returns the wrong word on a later pop. A wrong bound or a bad compare shows up as a flag that is set or missing on the very access at the boundary, so the bench checks both sides of each equality case. A flag that loses its sticky behaviour shows as a flag that drops without a clear on the cycle after it was set.

// File: rtl/stk_guard.sv
module stk_guard #(
  parameter int AW = 11,
  parameter logic [AW-1:0] SP_INIT  = 11'h600,
  parameter logic [AW-1:0] OVL_INIT = 11'h5F8,
  parameter logic [AW-1:0] UNL_INIT = 11'h600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [15:0]   push_data,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic [15:0]   pop_data,
  output logic          acc_done,
  input  logic          sp_wr,
  input  logic [AW-1:0] sp_wdata,
  input  logic          ovl_wr,
  input  logic [AW-1:0] ovl_wdata,
  input  logic          unl_wr,
  input  logic [AW-1:0] unl_wdata,
  input  logic          clr_ovf,
  input  logic          clr_unf,
  output logic [AW-1:0] sp_out,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata
);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [AW-1:0] EVEN = ~AW'(1);

  logic [AW-1:0] sp, ovl, unl, sp_dn, sp_up;
  logic do_push, do_pop, fire;

  assign do_push   = push_req & ~sp_wr;
  assign do_pop    = pop_req & ~push_req & ~sp_wr;
  assign sp_dn     = sp - STEP;
  assign sp_up     = sp + STEP;
  assign mem_req   = do_push | do_pop;
  assign mem_we    = do_push;
  assign mem_addr  = do_push ? sp_dn : sp;
  assign mem_wdata = push_data;
  assign fire      = mem_req & mem_gnt;
  assign acc_done  = fire;
  assign sp_out    = sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= SP_INIT & EVEN;
      ovl       <= OVL_INIT & EVEN;
      unl       <= UNL_INIT & EVEN;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      if (sp_wr)                sp <= sp_wdata & EVEN;
      else if (fire && do_push) sp <= sp_dn;
      else if (fire && do_pop)  sp <= sp_up;
      if (ovl_wr) ovl <= ovl_wdata & EVEN;
      if (unl_wr) unl <= unl_wdata & EVEN;
      ovf_flag  <= (fire & do_push & (sp_dn <= ovl)) | (ovf_flag & ~clr_ovf);
      unf_flag  <= (fire & do_pop & (sp_up > unl)) | (unf_flag & ~clr_unf);
      pop_valid <= fire & do_pop;
      if (fire && do_pop) pop_data <= mem_rdata;
    end
  end

  a_r2_push_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mem_we && !sp_wr) |=> sp_out == $past(mem_addr));
  a_r3_pop_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mem_we) |=> sp_out == $past(mem_addr) + STEP);
  a_r3_pop_data: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mem_we) |=> (pop_valid && pop_data == $past(mem_rdata)));
  a_r4_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
    sp_out[0] == 1'b0);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !clr_unf) |=> unf_flag);
  a_r8_no_access_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |-> !mem_req);
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !sp_wr) |=> $stable(sp_out));
endmodule

// File: tb/sim_stk_guard.sv
module sim_stk_guard;
  localparam int CLK_NS = 10;
  localparam int NV = 11;
  // {is_pop, wdata[15:0], exp_sp[10:0], exp_pop[15:0], exp_ovf, exp_unf}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 16'hA001, 11'h5FE, 16'h0000, 1'b0, 1'b0},
    {1'b0, 16'hA002, 11'h5FC, 16'h0000, 1'b0, 1'b0},
    {1'b1, 16'h0000, 11'h5FE, 16'hA002, 1'b0, 1'b0},
    {1'b0, 16'hA003, 11'h5FC, 16'h0000, 1'b0, 1'b0},
    {1'b0, 16'hA004, 11'h5FA, 16'h0000, 1'b0, 1'b0},
    {1'b0, 16'hA005, 11'h5F8, 16'h0000, 1'b1, 1'b0},
    {1'b1, 16'h0000, 11'h5FA, 16'hA005, 1'b1, 1'b0},
    {1'b1, 16'h0000, 11'h5FC, 16'hA004, 1'b1, 1'b0},
    {1'b1, 16'h0000, 11'h5FE, 16'hA003, 1'b1, 1'b0},
    {1'b1, 16'h0000, 11'h600, 16'hA001, 1'b1, 1'b0},
    {1'b1, 16'h0000, 11'h602, 16'h0000, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic push_req = 0, pop_req = 0, sp_wr = 0, ovl_wr = 0, unl_wr = 0;
  logic clr_ovf = 0, clr_unf = 0, gnt_en = 1;
  logic [15:0] push_data = 0;
  logic [10:0] sp_wdata = 0, ovl_wdata = 0, unl_wdata = 0;
  logic pop_valid, acc_done, ovf_flag, unf_flag, mem_req, mem_we, mem_gnt;
  logic [15:0] pop_data, mem_wdata, mem_rdata;
  logic [10:0] sp_out, mem_addr;
  logic [15:0] ram [1024];
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign mem_gnt   = mem_req & gnt_en;
  assign mem_rdata = ram[mem_addr[10:1]];
  always @(posedge clk) if (mem_req && mem_we && mem_gnt) ram[mem_addr[10:1]] <= mem_wdata;

  stk_guard u0 (.clk, .rst_n, .push_req, .push_data, .pop_req, .pop_valid, .pop_data,
    .acc_done, .sp_wr, .sp_wdata, .ovl_wr, .ovl_wdata, .unl_wr, .unl_wdata, .clr_ovf,
    .clr_unf, .sp_out, .ovf_flag, .unf_flag, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_gnt, .mem_rdata);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic pu, logic po, logic [15:0] d);
    push_req = pu; pop_req = po; push_data = d;
    @(negedge clk);
    push_req = 0; pop_req = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 sp", 16'(sp_out), 16'h600);
    chk("R1 ovf", 16'(ovf_flag), 0);
    chk("R1 unf", 16'(unf_flag), 0);
    chk("R1 req", 16'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(~VEC[v][45], VEC[v][45], VEC[v][44:29]);
      chk(VEC[v][45] ? "R3 sp after pop" : "R2 sp after push", 16'(sp_out), 16'(VEC[v][28:18]));
      if (VEC[v][45]) begin
        chk("R3 pop_valid", 16'(pop_valid), 1);
        chk("R3 pop_data", pop_data, VEC[v][17:2]);
      end
      chk("R5/R7 ovf", 16'(ovf_flag), 16'(VEC[v][1]));
      chk("R6 unf", 16'(unf_flag), 16'(VEC[v][0]));
    end

    clr_ovf = 1; @(negedge clk); clr_ovf = 0;
    chk("R7 ovf cleared", 16'(ovf_flag), 0);
    chk("R7 unf kept", 16'(unf_flag), 1);
    clr_unf = 1; @(negedge clk); clr_unf = 0;
    chk("R7 unf cleared", 16'(unf_flag), 0);

    sp_wr = 1; sp_wdata = 11'h3FF; push_req = 1; #1;
    chk("R8 no req on sp write", 16'(mem_req), 0);
    @(negedge clk); sp_wr = 0; push_req = 0;
    chk("R4 sp bit0 forced", 16'(sp_out), 16'h3FE);

    gnt_en = 0; push_req = 1; push_data = 16'h5555; #1;
    chk("R2 req", 16'(mem_req), 1);
    chk("R2 we", 16'(mem_we), 1);
    chk("R2 addr", 16'(mem_addr), 16'h3FC);
    chk("R2 wdata", mem_wdata, 16'h5555);
    @(negedge clk);
    chk("R9 sp held", 16'(sp_out), 16'h3FE);
    chk("R9 ovf held", 16'(ovf_flag), 0);
    push_req = 0; gnt_en = 1;

    pop_req = 1; #1;
    chk("R3 pop addr", 16'(mem_addr), 16'h3FE);
    chk("R3 pop we", 16'(mem_we), 0);
    pop_req = 0;

    clr_ovf = 1;
    step(1, 1, 16'hBEEF);
    clr_ovf = 0;
    chk("R8 push wins sp", 16'(sp_out), 16'h3FC);
    chk("R8 no pop_valid", 16'(pop_valid), 0);
    chk("R7 set beats clear", 16'(ovf_flag), 1);
    step(0, 1, 0);
    chk("R3 pop returns pushed", pop_data, 16'hBEEF);

    ovl_wr = 1; ovl_wdata = 11'h100; clr_ovf = 1; @(negedge clk); ovl_wr = 0; clr_ovf = 0;
    step(1, 0, 16'h1111);
    step(1, 0, 16'h2222);
    chk("R5 above bound no ovf", 16'(ovf_flag), 0);
    chk("R2 sp", 16'(sp_out), 16'h3FA);
    ovl_wr = 1; ovl_wdata = 11'h3F8; @(negedge clk); ovl_wr = 0;
    step(1, 0, 16'h3333);
    chk("R5 equal sets ovf", 16'(ovf_flag), 1);
    step(0, 1, 0);
    unl_wr = 1; unl_wdata = 11'h3FC; @(negedge clk); unl_wr = 0;
    step(0, 1, 0);
    chk("R6 equal no unf", 16'(unf_flag), 0);
    chk("R3 data", pop_data, 16'h2222);
    step(0, 1, 0);
    chk("R6 above sets unf", 16'(unf_flag), 1);
    chk("R3 data", pop_data, 16'h1111);
    chk("R7 access still done", 16'(sp_out), 16'h3FE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule